// File: doc/BRIEF.md
# Transactional Data Cache with Abort Control

This block is a small direct-mapped, write-back, write-allocate data cache. It doubles as the speculative store buffer for a single hardware transaction. A processor issues word loads and stores on one port and transaction commands on another. Between a begin and a commit, every store the processor makes stays inside the cache. Each line that holds such a store is tagged with a speculative mark, and backing memory never sees that data until the transaction commits. A commit turns every marked line into an ordinary dirty line in a single cycle. An abort discards every marked line in a single cycle and reports why it happened.

A transaction aborts in four cases: it would need to evict one of its own marked lines, the processor signals a context switch, software asks for an abort, or an access collides with data that a software-managed transaction owns. Two checks detect that last case. A load inside a transaction aborts if it returns the configured sentinel word. A store inside a transaction first reads a guard word at a configured distance from its target, and aborts if that word is non-zero. Backing memory is reached through a single request/acknowledge port with word granularity.

Top module: `txn_cache`

## Requirements
- R1: Outside a transaction, a load returns the value most recently stored to that word address. A line is indexed by the low log2(LINES) address bits. A dirty line is written to memory before a different tag takes its place, and no memory request is made while `req_ready` is high.
- R2: Commands are taken only while `req_ready` is high and are coded on `cmd_op` as 0 begin, 1 commit, 2 abort, 3 context switch. A begin sets `tx_active`. A begin while `tx_active` is high is ignored. Commit, abort and context switch while `tx_active` is low have no effect and raise no `abort_valid`.
- R3: A store made while `tx_active` is high marks its line and writes nothing to backing memory. A later load inside the same transaction returns the stored value.
- R4: A commit clears `tx_active` and every mark in one cycle. The stored values then behave as committed dirty data and reach memory when their lines are evicted.
- R5: An abort command while active pulses `abort_valid` with `abort_cause` = 2. Every marked line is dropped, so later loads return the value held before the transaction.
- R6: A context switch command while active aborts with `abort_cause` = 1 and drops the marked lines.
- R7: An access inside a transaction whose index holds a marked line with a different tag aborts with `abort_cause` = 0. The access still completes on `resp_valid` and its store data is discarded.
- R8: A load inside a transaction that returns a word equal to `cfg_flag` completes with that word and aborts with `abort_cause` = 3. Outside a transaction, the same load completes without an abort.
- R9: A store inside a transaction first reads the guard word at address `req_addr + cfg_rl_offset`, modulo 2^AW. A non-zero guard aborts with `abort_cause` = 3 and the store is dropped. A zero guard lets the store proceed.
- R10: Before a store inside a transaction modifies a dirty unmarked line, that line's committed value is written to memory. An abort then leaves that committed value readable.
- R11: `resp_valid` and `abort_valid` are one-cycle pulses. `abort_valid` is raised only while a transaction was active. `abort_cause` holds the code of the most recent abort until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Controller idle; request or command accepted |
| resp_valid | output | 1 | Access completed (one cycle) |
| resp_rdata | output | DW | Load result |
| cmd_valid | input | 1 | Transaction command valid; takes priority over a request |
| cmd_op | input | 2 | 0 begin, 1 commit, 2 abort, 3 context switch |
| cfg_flag | input | DW | Sentinel word marking software-owned data |
| cfg_rl_offset | input | AW | Distance from an accessed word to its guard word |
| mem_req | output | 1 | Backing-memory request |
| mem_write | output | 1 | 1 = write-back, 0 = line fill |
| mem_addr | output | AW | Backing-memory word address |
| mem_wdata | output | DW | Write-back data |
| mem_rdata | input | DW | Fill data, valid with `mem_ack` |
| mem_ack | input | 1 | Backing-memory completion |
| tx_active | output | 1 | A transaction is in progress |
| abort_valid | output | 1 | Abort happened this cycle |
| abort_cause | output | 2 | 0 capacity, 1 context switch, 2 explicit, 3 software conflict |

## Verification
The bench targets speculative data leaking or being lost. It inspects the memory model right after a transactional store and after a commit-then-evict sequence. A design that wrote speculative lines back would show the new value early, and one that forgot to keep committed lines dirty would never show it. For each of the four abort paths, the bench reloads the touched word afterwards. A design that failed to invalidate marked lines would return the discarded value, and one that skipped the pre-store write-back of a dirty unmarked line would lose the committed value after the abort. The sentinel and guard-word checks are run both inside and outside a transaction, and the ignored commands are sent both while active and while idle. An inverted condition or a wrong cause code therefore shows up as a missing, extra or mislabelled abort.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [1:0] {
    CAUSE_CAPACITY = 2'd0,
    CAUSE_CTXSW    = 2'd1,
    CAUSE_EXPLICIT = 2'd2,
    CAUSE_SWCONF   = 2'd3
  } abort_cause_e;

  typedef enum logic [1:0] {
    OP_BEGIN  = 2'd0,
    OP_COMMIT = 2'd1,
    OP_ABORT  = 2'd2,
    OP_CTXSW  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WB   = 2'd2,
    ST_FILL = 2'd3
  } ctrl_state_e;

endpackage

// File: rtl/txc_line_ram.sv
// Tag+data storage, one entry per line; no reset so it maps to RAM.
module txc_line_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];

endmodule

// File: rtl/txc_meta.sv
// Per-line state flops: valid, dirty, speculative mark. Bulk commit/abort.
module txc_meta #(
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(LINES)-1:0] idx,
  input  logic                     fill_we,
  input  logic                     wr_we,
  input  logic                     wr_mark,
  input  logic                     clean_we,
  input  logic                     commit_all,
  input  logic                     abort_all,
  output logic                     valid_o,
  output logic                     dirty_o,
  output logic                     mark_o,
  output logic [LINES-1:0]         marks_o
);

  logic [LINES-1:0] valid_q, dirty_q, mark_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      mark_q  <= '0;
    end else if (abort_all) begin
      valid_q <= valid_q & ~mark_q;
      dirty_q <= dirty_q & ~mark_q;
      mark_q  <= '0;
    end else if (commit_all) begin
      mark_q  <= '0;
    end else begin
      if (fill_we) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
        mark_q[idx]  <= 1'b0;
      end
      if (wr_we) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b1;
        mark_q[idx]  <= mark_q[idx] | wr_mark;
      end
      if (clean_we) dirty_q[idx] <= 1'b0;
    end
  end

  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];
  assign mark_o  = mark_q[idx];
  assign marks_o = mark_q;

endmodule

// File: rtl/txc_ctrl.sv
// Access sequencer, guard/sentinel checks, transaction state and abort cause.
module txc_ctrl
  import txc_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     req_ready,
  output logic                     resp_valid,
  output logic [DW-1:0]            resp_rdata,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [DW-1:0]            cfg_flag,
  input  logic [AW-1:0]            cfg_rl_offset,
  output logic [$clog2(LINES)-1:0] look_idx,
  input  logic [AW-$clog2(LINES)-1:0] line_tag,
  input  logic [DW-1:0]            line_data,
  input  logic                     line_valid,
  input  logic                     line_dirty,
  input  logic                     line_mark,
  output logic                     ram_we,
  output logic [DW-1:0]            ram_wdata,
  output logic                     fill_we,
  output logic                     wr_we,
  output logic                     wr_mark,
  output logic                     clean_we,
  output logic                     commit_all,
  output logic                     abort_all,
  output logic                     mem_req,
  output logic                     mem_write,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     mem_ack,
  output logic                     tx_active,
  output logic                     abort_valid,
  output logic [1:0]               abort_cause
);

  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW;

  ctrl_state_e          state_q;
  logic                 op_we_q, chk_q, tx_q;
  logic [AW-1:0]        op_addr_q, cur_addr_q;
  logic [DW-1:0]        op_wdata_q;
  logic [TAGW-1:0]      look_tag;
  logic                 hit, guard_set, need_keep_wb;
  logic                 evt_abort, evt_finish, evt_commit;
  abort_cause_e         evt_cause, cause_q;

  assign look_idx     = cur_addr_q[IDXW-1:0];
  assign look_tag     = cur_addr_q[AW-1:IDXW];
  assign hit          = line_valid && (line_tag == look_tag);
  assign guard_set    = (line_data != '0);
  assign need_keep_wb = op_we_q && tx_q && line_dirty && !line_mark;

  // Event decode for the current cycle
  always_comb begin
    evt_abort  = 1'b0;
    evt_finish = 1'b0;
    evt_commit = 1'b0;
    evt_cause  = CAUSE_CAPACITY;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid && tx_q) begin
          case (cmd_op_e'(cmd_op))
            OP_COMMIT: evt_commit = 1'b1;
            OP_ABORT:  begin evt_abort = 1'b1; evt_cause = CAUSE_EXPLICIT; end
            OP_CTXSW:  begin evt_abort = 1'b1; evt_cause = CAUSE_CTXSW; end
            default:   ;
          endcase
        end
      end
      ST_LOOK: begin
        if (hit) begin
          if (chk_q) begin
            if (guard_set) begin
              evt_abort  = 1'b1;
              evt_finish = 1'b1;
              evt_cause  = CAUSE_SWCONF;
            end
          end else if (!need_keep_wb) begin
            evt_finish = 1'b1;
            if (!op_we_q && tx_q && line_data == cfg_flag) begin
              evt_abort = 1'b1;
              evt_cause = CAUSE_SWCONF;
            end
          end
        end else if (line_valid && line_mark) begin
          evt_abort  = 1'b1;
          evt_finish = 1'b1;
          evt_cause  = CAUSE_CAPACITY;
        end
      end
      default: ;
    endcase
  end

  // Array and memory controls
  always_comb begin
    ram_we    = 1'b0;
    ram_wdata = op_wdata_q;
    fill_we   = 1'b0;
    wr_we     = 1'b0;
    wr_mark   = tx_q;
    clean_we  = 1'b0;
    mem_req   = 1'b0;
    mem_write = 1'b0;
    mem_addr  = cur_addr_q;
    mem_wdata = line_data;
    unique case (state_q)
      ST_LOOK: begin
        if (evt_finish && !evt_abort && op_we_q && !chk_q) begin
          ram_we = 1'b1;
          wr_we  = 1'b1;
        end
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_write = 1'b1;
        mem_addr  = {line_tag, look_idx};
        clean_we  = mem_ack;
      end
      ST_FILL: begin
        mem_req   = 1'b1;
        ram_we    = mem_ack;
        ram_wdata = mem_rdata;
        fill_we   = mem_ack;
      end
      default: ;
    endcase
  end

  assign commit_all = evt_commit;
  assign abort_all  = evt_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      op_we_q     <= 1'b0;
      chk_q       <= 1'b0;
      tx_q        <= 1'b0;
      op_addr_q   <= '0;
      cur_addr_q  <= '0;
      op_wdata_q  <= '0;
      resp_valid  <= 1'b0;
      resp_rdata  <= '0;
      abort_valid <= 1'b0;
      cause_q     <= CAUSE_CAPACITY;
    end else begin
      resp_valid  <= 1'b0;
      abort_valid <= 1'b0;
      if (evt_abort) begin
        abort_valid <= 1'b1;
        cause_q     <= evt_cause;
        tx_q        <= 1'b0;
      end
      if (evt_commit) tx_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (cmd_op_e'(cmd_op) == OP_BEGIN) tx_q <= 1'b1;
          end else if (req_valid) begin
            op_we_q    <= req_write;
            op_addr_q  <= req_addr;
            op_wdata_q <= req_wdata;
            chk_q      <= req_write && tx_q;
            cur_addr_q <= (req_write && tx_q) ? req_addr + cfg_rl_offset : req_addr;
            state_q    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (evt_finish) begin
            resp_valid <= 1'b1;
            resp_rdata <= line_data;
            state_q    <= ST_IDLE;
          end else if (hit && chk_q) begin
            chk_q      <= 1'b0;
            cur_addr_q <= op_addr_q;
          end else if (hit || (line_valid && line_dirty)) begin
            state_q <= ST_WB;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_WB:   if (mem_ack) state_q <= ST_LOOK;
        ST_FILL: if (mem_ack) state_q <= ST_LOOK;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign tx_active   = tx_q;
  assign abort_cause = cause_q;

endmodule

// File: rtl/txn_cache.sv
module txn_cache #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LINES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cfg_flag,
  input  logic [AW-1:0] cfg_rl_offset,
  output logic          mem_req,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          tx_active,
  output logic          abort_valid,
  output logic [1:0]    abort_cause
);

  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW;
  localparam int EW   = TAGW + DW;

  logic [IDXW-1:0] look_idx;
  logic [EW-1:0]   entry_rd, entry_wr;
  logic [DW-1:0]   ram_wdata;
  logic            ram_we, fill_we, wr_we, wr_mark, clean_we, commit_all, abort_all;
  logic            line_valid, line_dirty, line_mark;
  logic [LINES-1:0] mark_vec;

  assign entry_wr = {look_tag_w, ram_wdata};
  logic [TAGW-1:0] look_tag_w;
  logic [AW-1:0]   look_addr_unused;
  assign look_addr_unused = '0;

  txc_line_ram #(.DEPTH(LINES), .W(EW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (look_idx),
    .wdata (entry_wr),
    .raddr (look_idx),
    .rdata (entry_rd)
  );

  txc_meta #(.LINES(LINES)) u_meta (
    .clk        (clk),
    .rst        (rst),
    .idx        (look_idx),
    .fill_we    (fill_we),
    .wr_we      (wr_we),
    .wr_mark    (wr_mark),
    .clean_we   (clean_we),
    .commit_all (commit_all),
    .abort_all  (abort_all),
    .valid_o    (line_valid),
    .dirty_o    (line_dirty),
    .mark_o     (line_mark),
    .marks_o    (mark_vec)
  );

  txc_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_rdata    (resp_rdata),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cfg_flag      (cfg_flag),
    .cfg_rl_offset (cfg_rl_offset),
    .look_idx      (look_idx),
    .line_tag      (entry_rd[EW-1:DW]),
    .line_data     (entry_rd[DW-1:0]),
    .line_valid    (line_valid),
    .line_dirty    (line_dirty),
    .line_mark     (line_mark),
    .ram_we        (ram_we),
    .ram_wdata     (ram_wdata),
    .fill_we       (fill_we),
    .wr_we         (wr_we),
    .wr_mark       (wr_mark),
    .clean_we      (clean_we),
    .commit_all    (commit_all),
    .abort_all     (abort_all),
    .mem_req       (mem_req),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .mem_ack       (mem_ack),
    .tx_active     (tx_active),
    .abort_valid   (abort_valid),
    .abort_cause   (abort_cause)
  );

  // Tag written with an entry: the tag of the address being looked up.
  assign look_tag_w = u_ctrl.look_tag;

endmodule

// File: rtl/txn_cache_checker.sv
module txn_cache_checker #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             abort_valid,
  input logic             tx_active,
  input logic             mem_req,
  input logic             mem_write,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             line_mark,
  input logic [LINES-1:0] marks
);

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req) else $error("idle memory request"); // R1

  AST_BEGIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (req_ready && cmd_valid && cmd_op == 2'd0 && tx_active) |=> tx_active)
    else $error("nested begin changed state"); // R2

  AST_IDLE_CMD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_ready && cmd_valid && cmd_op != 2'd0 && !tx_active) |=> !abort_valid)
    else $error("abort while idle"); // R2

  AST_NO_SPEC_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_write) |-> !line_mark) else $error("marked line written back"); // R3

  AST_MARKS_ONLY_IN_TX: assert property (@(posedge clk) disable iff (rst)
    !tx_active |-> (marks == '0)) else $error("mark outlived transaction"); // R4

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid) else $error("resp not a pulse"); // R11

  AST_ABORT_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    abort_valid |-> $past(tx_active)) else $error("abort without transaction"); // R11

endmodule

bind txn_cache txn_cache_checker #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .abort_valid (abort_valid),
  .tx_active   (tx_active),
  .mem_req     (mem_req),
  .mem_write   (mem_write),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .line_mark   (line_mark),
  .marks       (mark_vec)
);

// File: tb/sim_txn_cache.sv
`timescale 1ns/1ps
module sim_txn_cache;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int LINES = 8;
  localparam logic [DW-1:0] FLAG = 32'hDEAD_0001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, resp_valid;
  logic [DW-1:0] resp_rdata;
  logic          cmd_valid = 0;
  logic [1:0]    cmd_op = '0;
  logic          mem_req, mem_write, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          tx_active, abort_valid;
  logic [1:0]    abort_cause;

  txn_cache #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cfg_flag(FLAG), .cfg_rl_offset(10'h204),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_active(tx_active), .abort_valid(abort_valid), .abort_cause(abort_cause)
  );

  // Backing memory model: one-cycle acknowledge
  logic [DW-1:0] bmem [0:(1<<AW)-1];
  logic          ack_q = 1'b0;
  logic [DW-1:0] rd_q = '0;
  assign mem_ack = ack_q;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_req && !ack_q) begin
      ack_q <= 1'b1;
      if (mem_write) bmem[mem_addr] <= mem_wdata;
      else rd_q <= bmem[mem_addr];
    end else begin
      ack_q <= 1'b0;
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  typedef struct {
    string         rq;
    logic          chk_data;
    logic [DW-1:0] data;
    logic          abt;
    logic [1:0]    cause;
  } exp_t;
  exp_t sbq[$];

  // Monitor: pops one expected item per completed access
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (sbq.size() == 0) begin
        check("R1 unexpected response", 1, 0);
      end else begin
        exp_t it;
        it = sbq.pop_front();
        if (it.chk_data) check({it.rq, " data"}, resp_rdata, it.data);
        check({it.rq, " abort flag"}, {31'd0, abort_valid}, {31'd0, it.abt});
        if (it.abt) check({it.rq, " cause"}, {30'd0, abort_cause}, {30'd0, it.cause});
      end
    end
  end

  // Driver: queues the expectation and issues one access
  task automatic access(input string rq, input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic chkd, input logic [DW-1:0] ed,
                        input logic ab, input logic [1:0] cs);
    exp_t it;
    it.rq = rq; it.chk_data = chkd; it.data = ed; it.abt = ab; it.cause = cs;
    sbq.push_back(it);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic command(input string rq, input logic [1:0] op, input logic ab,
                         input logic [1:0] cs, input logic txe);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0;
    check({rq, " abort flag"}, {31'd0, abort_valid}, {31'd0, ab});
    check({rq, " cause"}, {30'd0, abort_cause}, {30'd0, cs});
    check({rq, " tx_active"}, {31'd0, tx_active}, {31'd0, txe});
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) bmem[i] = (i < 'h200) ? 32'h1000 + i : 32'd0;
    bmem['h030] = FLAG;
    bmem['h219] = 32'd5;   // guard word for 0x015
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 reset ready", {31'd0, req_ready}, 1);
    check("R2 reset tx_active", {31'd0, tx_active}, 0);
    check("R11 reset abort_valid", {31'd0, abort_valid}, 0);

    // R1 plain cache behaviour with eviction
    access("R1 cold load", 0, 'h010, 0, 1, 32'h1010, 0, 0);
    access("R1 store", 1, 'h010, 32'hA1, 0, 0, 0, 0);
    access("R1 load after store", 0, 'h010, 0, 1, 32'hA1, 0, 0);
    access("R1 conflicting store", 1, 'h028, 32'hB2, 0, 0, 0, 0);
    check("R1 dirty victim written back", bmem['h010], 32'hA1);
    access("R1 reload evicted", 0, 'h010, 0, 1, 32'hA1, 0, 0);
    check("R1 second write-back", bmem['h028], 32'hB2);

    // R2 R3 R4 speculative store, nested begin, commit
    command("R2 begin", 2'd0, 0, 2'd0, 1);
    access("R3 tx store", 1, 'h011, 32'hC3, 0, 0, 0, 0);
    check("R3 memory untouched", bmem['h011], 32'h1011);
    access("R3 tx load sees store", 0, 'h011, 0, 1, 32'hC3, 0, 0);
    command("R2 nested begin ignored", 2'd0, 0, 2'd0, 1);
    command("R4 commit", 2'd1, 0, 2'd0, 0);
    access("R4 evicting load", 0, 'h019, 0, 1, 32'h1019, 0, 0);
    check("R4 committed data written back", bmem['h011], 32'hC3);

    // R5 explicit abort
    command("R5 begin", 2'd0, 0, 2'd0, 1);
    access("R5 tx store", 1, 'h012, 32'hD4, 0, 0, 0, 0);
    command("R5 explicit abort", 2'd2, 1, 2'd2, 0);
    access("R5 old value back", 0, 'h012, 0, 1, 32'h1012, 0, 0);

    // R6 context switch
    command("R6 begin", 2'd0, 0, 2'd2, 1);
    access("R6 tx store", 1, 'h013, 32'hE5, 0, 0, 0, 0);
    command("R6 context switch", 2'd3, 1, 2'd1, 0);
    access("R6 old value back", 0, 'h013, 0, 1, 32'h1013, 0, 0);

    // R7 capacity overflow
    command("R7 begin", 2'd0, 0, 2'd1, 1);
    access("R7 tx store", 1, 'h014, 32'hF6, 0, 0, 0, 0);
    access("R7 conflicting load", 0, 'h01C, 0, 0, 0, 1, 2'd0);
    check("R7 tx_active cleared", {31'd0, tx_active}, 0);
    access("R7 old value back", 0, 'h014, 0, 1, 32'h1014, 0, 0);

    // R8 sentinel load
    access("R8 sentinel outside tx", 0, 'h030, 0, 1, FLAG, 0, 0);
    command("R8 begin", 2'd0, 0, 2'd0, 1);
    access("R8 sentinel inside tx", 0, 'h030, 0, 1, FLAG, 1, 2'd3);
    check("R8 tx_active cleared", {31'd0, tx_active}, 0);

    // R9 guard word non-zero
    command("R9 begin", 2'd0, 0, 2'd3, 1);
    access("R9 guarded store", 1, 'h015, 32'h77, 0, 0, 1, 2'd3);
    access("R9 store dropped", 0, 'h015, 0, 1, 32'h1015, 0, 0);
    check("R9 memory untouched", bmem['h015], 32'h1015);

    // R10 committed dirty line protected
    access("R10 plain store", 1, 'h016, 32'h66, 0, 0, 0, 0);
    command("R10 begin", 2'd0, 0, 2'd3, 1);
    access("R10 tx store over dirty", 1, 'h016, 32'h99, 0, 0, 0, 0);
    check("R10 committed value flushed", bmem['h016], 32'h66);
    access("R10 tx load", 0, 'h016, 0, 1, 32'h99, 0, 0);
    command("R10 abort", 2'd2, 1, 2'd2, 0);
    access("R10 committed value kept", 0, 'h016, 0, 1, 32'h66, 0, 0);

    // R2 R11 commands while idle
    command("R2 commit while idle", 2'd1, 0, 2'd2, 0);
    command("R2 abort while idle", 2'd2, 0, 2'd2, 0);
    command("R11 ctxsw while idle", 2'd3, 0, 2'd2, 0);

    repeat (4) @(negedge clk);
    check("R11 scoreboard drained", sbq.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule